// File: doc/BRIEF.md
# Cache Line Load Extractor

This block sits after the data array of a cache. The array returns a whole 64-byte line, split across eight banks, and the block turns that line into the one value a load asked for. Each bank is an 8-byte word. Bank b holds line bytes 8b to 8b+7, with byte k of the line at bits `[8k+7:8k]` of the flat `bank_data` bus. The banks are therefore joined in address order. Each line byte comes with its own even-parity bit, and bit k of `bank_par` belongs to byte k.

The line is rotated right by the byte offset through a six-stage logarithmic barrel shifter. The low bytes are then kept according to the size code and filled with zeros or with copies of the sign. The parity of every byte is checked in parallel. A mismatch counts only if it falls in a bank that the access touches. An access whose offset plus size runs past byte 63 is reported as misaligned. Its bytes wrap around to byte 0, and the bench treats the data it returns as undefined.

A two-state controller times the output. `ST_IDLE` moves to `ST_HOLD` when `line_vld` is high. `ST_HOLD` stays in `ST_HOLD` while `line_vld` stays high and returns to `ST_IDLE` otherwise. `ld_vld` is high exactly in `ST_HOLD`, so each result appears one clock after its line.

Top module: `line_load_extract`

## Requirements
- R1: During and right after reset, `ld_vld`, `ld_data`, `ld_par_err` and `ld_mis_err` are all 0.
- R2: A line presented with `line_vld` high in one cycle gives exactly one result with `ld_vld` high in the next cycle. No result appears without a line.
- R3: Result byte i equals line byte (offset + i) mod 64, where line byte k is `bank_data[8k+7:8k]` (bank k/8, lane k mod 8).
- R4: The size code selects how many bytes are kept: 2'b00 keeps 1, 2'b01 keeps 2, 2'b10 keeps 4 and 2'b11 keeps 8.
- R5: With `sign_ext` = 0, every result byte above the kept bytes is 0.
- R6: With `sign_ext` = 1, every result byte above the kept bytes is a copy of bit 7 of the highest kept byte. An 8-byte access is unchanged by this.
- R7: Parity is even: byte k is correct when the XOR of its 8 bits equals `bank_par[k]`. `ld_par_err` is set when any byte in any bank from bank offset/8 through the bank holding byte min(offset+size−1, 63) fails this test, even if the failing byte was not requested.
- R8: A parity failure confined to banks outside that range leaves `ld_par_err` at 0.
- R9: `ld_mis_err` is set exactly when offset + size > 64. An access ending on byte 63 is not misaligned.
- R10: Whenever `ld_vld` is 0, `ld_data`, `ld_par_err` and `ld_mis_err` are 0.
- R11: Lines presented in consecutive cycles give results in consecutive cycles, in the same order, with no loss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_vld | input | 1 | Line and request fields are valid this cycle |
| bank_data | input | 512 | Eight 64-bit bank words, bank 0 in the low bits |
| bank_par | input | 64 | Even-parity bit per line byte |
| byte_off | input | 6 | Byte offset of the load within the line |
| size_code | input | 2 | Access size: 00=1, 01=2, 10=4, 11=8 bytes |
| sign_ext | input | 1 | 1 = sign-extend, 0 = zero-extend |
| ld_vld | output | 1 | Result valid |
| ld_data | output | 64 | Extracted, extended load value |
| ld_par_err | output | 1 | Parity failure in a touched bank |
| ld_mis_err | output | 1 | Access runs past the end of the line |

## Verification
The bench targets the line boundary with these accesses:
- offset 63 with 1 byte, offset 60 with 4 bytes and offset 56 with 8 bytes, which are legal;
- offset 63 with 2 bytes, offset 61 with 4 bytes and offset 57 with 8 bytes, which cross the end.

An off-by-one in the end-of-line test would flag a legal access or miss a crossing one. Parity is corrupted in three places:
- an unrequested byte of a touched bank, which must raise the error;
- a bank the access never reaches;
- the wrapped bank 0 of a misaligned access.

A range check keyed to the requested bytes or the wrapped bytes would get one of these cases wrong. Every size is run with both extension modes on values whose top bit is both set and clear. A design with a wrong fill source or fill width would show upper bytes that do not match. Back-to-back lines followed by gaps expose a controller that drops, repeats or holds a result.

// File: rtl/lle_pkg.sv
package lle_pkg;

    typedef enum logic [1:0] {
        SZ_B1 = 2'b00,
        SZ_B2 = 2'b01,
        SZ_B4 = 2'b10,
        SZ_B8 = 2'b11
    } size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } state_e;

    function automatic logic [3:0] size_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

endpackage

// File: rtl/lle_bank_check.sv
module lle_bank_check #(
    parameter int NUM_BANKS  = 8,
    parameter int BANK_BYTES = 8,
    localparam int LINE_BYTES = NUM_BANKS * BANK_BYTES,
    localparam int LINE_W     = LINE_BYTES * 8
) (
    input  logic [LINE_W-1:0]     line,
    input  logic [LINE_BYTES-1:0] par,
    output logic [NUM_BANKS-1:0]  bank_bad
);

    logic [LINE_BYTES-1:0] byte_bad;

    for (genvar k = 0; k < LINE_BYTES; k++) begin : g_byte
        // even parity: data bits XOR check bit must be zero
        assign byte_bad[k] = (^line[k*8 +: 8]) ^ par[k];
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bank_bad[b] = |byte_bad[b*BANK_BYTES +: BANK_BYTES];
    end

endmodule

// File: rtl/lle_rotate.sv
module lle_rotate #(
    parameter int LINE_BYTES = 64,
    parameter int OUT_BYTES  = 8,
    localparam int LINE_W = LINE_BYTES * 8,
    localparam int OUT_W  = OUT_BYTES * 8,
    localparam int SH_W   = $clog2(LINE_BYTES)
) (
    input  logic [LINE_W-1:0] line,
    input  logic [SH_W-1:0]   shamt,
    output logic [OUT_W-1:0]  out_bytes
);

    // one mux stage per offset bit, each rotating right by 2^s bytes
    always_comb begin
        logic [LINE_W-1:0] t;
        t = line;
        for (int s = 0; s < SH_W; s++) begin
            if (shamt[s]) begin
                t = (t >> (8 << s)) | (t << (LINE_W - (8 << s)));
            end
        end
        out_bytes = OUT_W'(t);
    end

endmodule

// File: rtl/lle_extend.sv
module lle_extend import lle_pkg::*; #(
    parameter int RES_BYTES = 8,
    localparam int RES_W = RES_BYTES * 8
) (
    input  logic [RES_W-1:0] raw,
    input  size_e            size_code,
    input  logic             sign_ext,
    output logic [RES_W-1:0] data
);

    always_comb begin
        int   len;
        logic fill;
        len  = int'(size_bytes(size_code));
        fill = sign_ext & raw[len*8 - 1];
        for (int i = 0; i < RES_BYTES; i++) begin
            data[i*8 +: 8] = (i < len) ? raw[i*8 +: 8] : {8{fill}};
        end
    end

endmodule

// File: rtl/line_load_extract.sv
module line_load_extract import lle_pkg::*; #(
    parameter int LINE_BYTES = 64,
    parameter int BANK_BYTES = 8,
    parameter int RES_BYTES  = 8,
    localparam int NUM_BANKS = LINE_BYTES / BANK_BYTES,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int RES_W     = RES_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  line_vld,
    input  logic [LINE_W-1:0]     bank_data,
    input  logic [LINE_BYTES-1:0] bank_par,
    input  logic [OFF_W-1:0]      byte_off,
    input  logic [1:0]            size_code,
    input  logic                  sign_ext,
    output logic                  ld_vld,
    output logic [RES_W-1:0]      ld_data,
    output logic                  ld_par_err,
    output logic                  ld_mis_err
);

    localparam int BANK_SH = $clog2(BANK_BYTES);
    localparam int BK_W    = OFF_W - BANK_SH;
    localparam int SUM_W   = OFF_W + 1;

    state_e             state_q, state_d;
    logic [SUM_W-1:0]   len_w, end_sum;
    logic               mis_c, par_c;
    logic [OFF_W-1:0]   last_byte;
    logic [BK_W-1:0]    first_bk, last_bk;
    logic [NUM_BANKS-1:0] bank_bad, touched;
    logic [RES_W-1:0]   rot_lo, ext_c;

    logic [RES_W-1:0]   data_q;
    logic               par_q, mis_q, sgn_q;
    size_e              size_q;

    // ---------------- datapath ----------------
    lle_bank_check #(.NUM_BANKS(NUM_BANKS), .BANK_BYTES(BANK_BYTES)) u_chk (
        .line     (bank_data),
        .par      (bank_par),
        .bank_bad (bank_bad)
    );

    lle_rotate #(.LINE_BYTES(LINE_BYTES), .OUT_BYTES(RES_BYTES)) u_rot (
        .line      (bank_data),
        .shamt     (byte_off),
        .out_bytes (rot_lo)
    );

    lle_extend #(.RES_BYTES(RES_BYTES)) u_ext (
        .raw       (rot_lo),
        .size_code (size_e'(size_code)),
        .sign_ext  (sign_ext),
        .data      (ext_c)
    );

    // end-of-access arithmetic and touched-bank window
    always_comb begin
        len_w     = SUM_W'(size_bytes(size_code));
        end_sum   = {1'b0, byte_off} + len_w;
        mis_c     = end_sum > SUM_W'(LINE_BYTES);
        last_byte = mis_c ? OFF_W'(LINE_BYTES - 1) : OFF_W'(end_sum - 1'b1);
        first_bk  = byte_off[OFF_W-1:BANK_SH];
        last_bk   = last_byte[OFF_W-1:BANK_SH];
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_touch
        assign touched[b] = (BK_W'(b) >= first_bk) && (BK_W'(b) <= last_bk);
    end

    assign par_c = |(bank_bad & touched);

    // ---------------- controller ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = line_vld ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_d = line_vld ? ST_HOLD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !line_vld) begin
            data_q <= '0;
            par_q  <= 1'b0;
            mis_q  <= 1'b0;
            sgn_q  <= 1'b0;
            size_q <= SZ_B1;
        end else begin
            data_q <= ext_c;
            par_q  <= par_c;
            mis_q  <= mis_c;
            sgn_q  <= sign_ext;
            size_q <= size_e'(size_code);
        end
    end

    always_comb begin
        ld_vld     = (state_q == ST_HOLD);
        ld_data    = data_q;
        ld_par_err = par_q;
        ld_mis_err = mis_q;
    end

    // ---------------- assertions ----------------
    assert_vld_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        line_vld |=> ld_vld);

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !line_vld |=> !ld_vld);

    assert_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_vld && !sgn_q && size_q == SZ_B1) |-> (ld_data[RES_W-1:8] == '0));

    assert_sign_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_vld && sgn_q && size_q == SZ_B2) |-> (ld_data[RES_W-1:16] == {(RES_W-16){ld_data[15]}}));

    assert_cross_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (line_vld && size_code == 2'b11 && byte_off > OFF_W'(LINE_BYTES - 8)) |=> ld_mis_err);

    assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_vld |-> (ld_data == '0 && !ld_par_err && !ld_mis_err));

endmodule

// File: tb/line_load_extract_test.sv
`timescale 1ns/1ps
module line_load_extract_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         line_vld = 1'b0;
    logic [511:0] bank_data = '0;
    logic [63:0]  bank_par = '0;
    logic [5:0]   byte_off = '0;
    logic [1:0]   size_code = '0;
    logic         sign_ext = 1'b0;
    logic         ld_vld;
    logic [63:0]  ld_data;
    logic         ld_par_err;
    logic         ld_mis_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [511:0] cur_line;
    logic [63:0]  cur_par;

    logic [63:0] exp_data_q[$];
    logic        exp_par_q[$];
    logic        exp_mis_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;   // 250 MHz

    line_load_extract uut (
        .clk(clk), .rst_n(rst_n), .line_vld(line_vld),
        .bank_data(bank_data), .bank_par(bank_par),
        .byte_off(byte_off), .size_code(size_code), .sign_ext(sign_ext),
        .ld_vld(ld_vld), .ld_data(ld_data),
        .ld_par_err(ld_par_err), .ld_mis_err(ld_mis_err)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic new_line();
        for (int w = 0; w < 16; w++) cur_line[w*32 +: 32] = $urandom;
        for (int k = 0; k < 64; k++) cur_par[k] = ^cur_line[k*8 +: 8];
    endtask

    task automatic set_byte(input int k, input logic [7:0] v);
        cur_line[k*8 +: 8] = v;
        cur_par[k] = ^v;
    endtask

    // driver: present one request and push its expected result
    task automatic send(input int off, input int sz, input bit sgn, input string tag);
        logic [63:0] e;
        int len, lastb;
        bit pe, me;
        @(negedge clk);
        line_vld  = 1'b1;
        bank_data = cur_line;
        bank_par  = cur_par;
        byte_off  = off[5:0];
        size_code = sz[1:0];
        sign_ext  = sgn;
        len = 1 << sz;
        e = '0;
        for (int i = 0; i < len; i++) e[i*8 +: 8] = cur_line[((off + i) % 64)*8 +: 8];
        if (sgn && len < 8 && e[len*8 - 1])
            for (int j = len*8; j < 64; j++) e[j] = 1'b1;
        me = (off + len) > 64;
        lastb = me ? 63 : off + len - 1;
        pe = 1'b0;
        for (int k = (off/8)*8; k < (lastb/8)*8 + 8; k++)
            if ((^cur_line[k*8 +: 8]) != cur_par[k]) pe = 1'b1;
        exp_data_q.push_back(e);
        exp_par_q.push_back(pe);
        exp_mis_q.push_back(me);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            line_vld = 1'b0;
        end
    endtask

    // monitor: compare each result against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n) begin
                if (ld_vld) begin
                    if (exp_data_q.size() == 0) begin
                        chk(1'b0, "R2 unexpected result", 64'(ld_vld), 64'd0);
                    end else begin
                        logic [63:0] e;
                        logic pe, me;
                        string t;
                        e = exp_data_q.pop_front();
                        pe = exp_par_q.pop_front();
                        me = exp_mis_q.pop_front();
                        t = tag_q.pop_front();
                        // a misaligned access returns undefined data
                        if (!me) chk(ld_data == e, {t, " data"}, ld_data, e);
                        chk(ld_par_err == pe, {t, " R7 parity flag"}, 64'(ld_par_err), 64'(pe));
                        chk(ld_mis_err == me, {t, " R9 misaligned flag"}, 64'(ld_mis_err), 64'(me));
                    end
                end else begin
                    chk(ld_data == '0 && !ld_par_err && !ld_mis_err, "R10 quiet while idle",
                        {ld_data[61:0], ld_par_err, ld_mis_err}, 64'd0);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R2 watchdog expired", 64'd0, 64'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        new_line();
        repeat (3) @(negedge clk);
        // R1: outputs low during reset
        chk(!ld_vld && ld_data == '0 && !ld_par_err && !ld_mis_err, "R1 during reset",
            {ld_data[61:0], ld_vld, ld_par_err}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ld_vld && ld_data == '0 && !ld_par_err && !ld_mis_err, "R1 after reset",
            {ld_data[61:0], ld_vld, ld_par_err}, 64'd0);

        // R3 R4: whole-word loads at bank starts and odd offsets
        send(0, 3, 1'b0, "R3 off0 8B");
        idle(1);
        send(8, 3, 1'b0, "R3 off8 8B");
        send(27, 3, 1'b0, "R3 off27 8B");
        idle(2);
        // R4: each size
        send(13, 0, 1'b0, "R4 1B");
        send(13, 1, 1'b0, "R4 2B");
        send(13, 2, 1'b0, "R4 4B");
        idle(1);

        // R5 R6: negative and positive values, both modes, all sizes
        new_line();
        set_byte(4, 8'h9C); set_byte(5, 8'hA1); set_byte(7, 8'hF0);
        set_byte(10, 8'h7F); set_byte(11, 8'h35);
        for (int sz = 0; sz < 4; sz++) begin
            send(4, sz, 1'b0, "R5 zero-extend negative");
            send(4, sz, 1'b1, "R6 sign-extend negative");
        end
        send(10, 0, 1'b1, "R6 sign-extend positive 1B");
        send(10, 1, 1'b0, "R5 zero-extend positive 2B");
        idle(2);

        // R7: bad parity in requested byte, and in an unrequested byte of a touched bank
        new_line();
        cur_par[21] ^= 1'b1;
        send(20, 1, 1'b0, "R7 requested byte bad");
        new_line();
        cur_par[15] ^= 1'b1;
        send(6, 2, 1'b0, "R7 touched bank unrequested byte");
        // R8: bad parity in an untouched bank
        new_line();
        cur_par[40] ^= 1'b1;
        send(0, 3, 1'b0, "R8 untouched bank");
        send(48, 0, 1'b1, "R8 later bank");
        idle(1);

        // R9: end-of-line boundary
        new_line();
        send(63, 0, 1'b1, "R9 off63 1B legal");
        send(60, 2, 1'b0, "R9 off60 4B legal");
        send(56, 3, 1'b0, "R9 off56 8B legal");
        send(62, 1, 1'b0, "R9 off62 2B legal");
        send(63, 1, 1'b0, "R9 off63 2B crosses");
        send(61, 2, 1'b0, "R9 off61 4B crosses");
        send(57, 3, 1'b0, "R9 off57 8B crosses");
        cur_par[1] ^= 1'b1;
        send(60, 3, 1'b0, "R9 wrapped bank not checked");
        idle(2);

        // R11: long back-to-back stream with a new line every cycle
        for (int n = 0; n < 40; n++) begin
            new_line();
            if (n % 5 == 0) cur_par[$urandom_range(63, 0)] ^= 1'b1;
            send($urandom_range(63, 0), $urandom_range(3, 0), 1'($urandom_range(1, 0)), "R11 stream");
        end
        idle(4);

        chk(exp_data_q.size() == 0, "R2 R11 every request answered",
            64'(exp_data_q.size()), 64'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule